// File: doc/BRIEF.md
# Bit Manipulation and Funnel Shift Execution Unit

This unit executes one operation per cycle from a group of 32-bit bit-manipulation instructions. Each operation takes a destination operand, a source operand, a bit index or shift count, a size code and the incoming carry and zero flags. One clock edge after `in_valid`, the unit returns a 32-bit result, a second 32-bit result and updated carry and zero flags. Operations that do not write a flag pass the incoming value through unchanged.

The operations fall into four families:
- Single-bit operations. These test a bit and can also set, clear or invert it. The old value of the bit goes to carry.
- Scans. These find the lowest or the highest set bit.
- Widening. This covers sign and zero extension of a byte or a halfword, halfword-to-word sign fill, and word-to-doubleword sign fill into the second result.
- Double-precision shifts. These move bits from the source into the destination, in either direction.

The surrounding pipeline supplies the operands and the flags, and writes back the results.

Top module: `bitx_unit`

## Requirements
- R1: Opcode 0 (test): on the next clock, `res` equals `in_dst`, `cf` equals bit `in_cnt` of `in_dst`, and `zf` equals `zf_in`. The bit index is the 5-bit `in_cnt`, so it is taken modulo 32.
- R2: Opcodes 1, 2 and 3 each place bit `in_cnt` of `in_dst` in `cf`. They then return `in_dst` with that bit forced to 1 (opcode 1), forced to 0 (opcode 2) or inverted (opcode 3). `zf` passes through.
- R3: Opcode 4 returns the index of the lowest set bit of `in_src`, and opcode 5 returns the index of the highest set bit. The index is zero-extended to 32 bits and `zf` is 0. `cf` passes through.
- R4: When `in_src` is zero, opcodes 4 and 5 set `zf` to 1 and return `in_dst` unchanged.
- R5: Opcode 6 sign-extends and opcode 7 zero-extends the low part of `in_src` to 32 bits. The low part is the low byte when `in_size` is 0 and the low halfword when `in_size` is 1. Both flags pass through.
- R6: Opcode 8 returns the low halfword of `in_dst` with bits 31..16 filled from bit 15 of `in_dst`. Both flags pass through.
- R7: Opcode 9 returns `in_dst` unchanged in `res`. It sets every bit of `res_hi` to bit 31 of `in_dst`. Both flags pass through.
- R8: Opcode 10 with a count n from 1 to 31 shifts `in_dst` left by n and fills bits n-1..0 with the top n bits of `in_src`. `cf` is bit 32-n of `in_dst`, and `zf` is 1 exactly when the result is zero.
- R9: Opcode 11 with a count n from 1 to 31 shifts `in_dst` right by n and fills the top n bits with the low n bits of `in_src`. `cf` is bit n-1 of `in_dst`, and `zf` is 1 exactly when the result is zero.
- R10: Opcodes 10 and 11 with a count of zero return `in_dst` unchanged, with `cf` and `zf` equal to the incoming flags.
- R11: Results appear on the clock edge after `in_valid` is seen, with `out_valid` high for that one cycle. `res_hi` is zero for every opcode except 9. Opcodes 12 to 15 return `in_dst` with both flags passed through. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| in_op | input | 4 | Opcode (0 to 11 defined) |
| in_size | input | 1 | Extension source size: 0 byte, 1 halfword |
| in_dst | input | 32 | Destination operand |
| in_src | input | 32 | Source operand |
| in_cnt | input | 5 | Bit index or shift count |
| cf_in | input | 1 | Incoming carry flag |
| zf_in | input | 1 | Incoming zero flag |
| out_valid | output | 1 | Result valid |
| res | output | 32 | Primary result |
| res_hi | output | 32 | Secondary result (sign fill for opcode 9) |
| cf | output | 1 | Carry flag out |
| zf | output | 1 | Zero flag out |

## Verification
The assertions compare each registered output with the inputs sampled one cycle earlier through `$past`. This is only valid if a request's operands, flags and opcode are held stable for the whole cycle in which `in_valid` is high. It also assumes no reset arrives between a request and its result. The bench meets both conditions by changing every input only on the falling edge and by releasing reset before the first request. The stimulus covers the shift cases where the count is zero and the scan cases where the source is all zeros, so the properties guarding those corners are exercised and not left untriggered.

// File: rtl/bitx_pkg.sv
// Shared opcode encoding for the bit manipulation unit.
// Assumes a 4-bit opcode; the single-bit group must occupy codes 0..3
// because its low two bits select the modify action.
package bitx_pkg;
    typedef enum logic [3:0] {
        OP_BTEST = 4'd0,
        OP_BSET  = 4'd1,
        OP_BCLR  = 4'd2,
        OP_BINV  = 4'd3,
        OP_SCANL = 4'd4,
        OP_SCANH = 4'd5,
        OP_SEXT  = 4'd6,
        OP_ZEXT  = 4'd7,
        OP_HFILL = 4'd8,
        OP_WFILL = 4'd9,
        OP_FSHL  = 4'd10,
        OP_FSHR  = 4'd11
    } bitx_op_e;
endpackage

// File: rtl/bitx_bitop.sv
// Single-bit test and modify.
// Reports the addressed bit and returns the operand with that bit kept,
// set, cleared or inverted, as chosen by act (0 keep, 1 set, 2 clear, 3 invert).
// Assumes the index is already reduced to the operand width.
module bitx_bitop #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [1:0]    act,
    input  logic [W-1:0]  val,
    input  logic [IW-1:0] idx,
    output logic [W-1:0]  res,
    output logic          bit_old
);
    logic [W-1:0] mask;

    // Decode the index into a one-hot mask and apply the chosen action.
    always_comb begin
        mask    = {{(W-1){1'b0}}, 1'b1} << idx;
        bit_old = val[idx];
        case (act)
            2'd1:    res = val | mask;
            2'd2:    res = val & ~mask;
            2'd3:    res = val ^ mask;
            default: res = val;
        endcase
    end
endmodule

// File: rtl/bitx_scan.sv
// Set-bit scanner. REVERSE = 0 returns the lowest set bit index,
// REVERSE = 1 the highest. 'none' flags an all-zero input, in which case
// idx is zero and meaningless.
module bitx_scan #(
    parameter int W       = 32,
    parameter int IW      = $clog2(W),
    parameter bit REVERSE = 1'b0
) (
    input  logic [W-1:0]  val,
    output logic [IW-1:0] idx,
    output logic          none
);
    assign none = (val == '0);

    generate
        if (REVERSE) begin : g_high
            // Walk upward so the last hit is the highest set bit.
            always_comb begin
                idx = '0;
                for (int i = 0; i < W; i++)
                    if (val[i]) idx = IW'(i);
            end
        end else begin : g_low
            // Walk downward so the last hit is the lowest set bit.
            always_comb begin
                idx = '0;
                for (int i = W - 1; i >= 0; i--)
                    if (val[i]) idx = IW'(i);
            end
        end
    endgenerate
endmodule

// File: rtl/bitx_extend.sv
// Widening operations: sign or zero extension of a byte or halfword,
// halfword sign fill, and word sign fill into a second result.
// Assumes W >= 16; for opcodes outside this group the operand passes through.
module bitx_extend #(
    parameter int W = 32
) (
    input  bitx_pkg::bitx_op_e op,
    input  logic               size,
    input  logic [W-1:0]       opnd,
    output logic [W-1:0]       res,
    output logic [W-1:0]       hi
);
    import bitx_pkg::*;

    logic [W-1:0] lo_sext, lo_zext;

    // Build both extensions of the selected low field.
    always_comb begin
        if (size) begin
            lo_sext = {{(W-16){opnd[15]}}, opnd[15:0]};
            lo_zext = {{(W-16){1'b0}},     opnd[15:0]};
        end else begin
            lo_sext = {{(W-8){opnd[7]}}, opnd[7:0]};
            lo_zext = {{(W-8){1'b0}},    opnd[7:0]};
        end
    end

    // Pick the result for the requested widening operation.
    always_comb begin
        res = opnd;
        hi  = '0;
        case (op)
            OP_SEXT:  res = lo_sext;
            OP_ZEXT:  res = lo_zext;
            OP_HFILL: res = {{(W-16){opnd[15]}}, opnd[15:0]};
            OP_WFILL: hi  = {W{opnd[W-1]}};
            default:  ;
        endcase
    end
endmodule

// File: rtl/bitx_dshift.sv
// Funnel shift of dst by cnt, pulling fill bits from src, left or right.
// Also returns the last bit shifted out of dst. Assumes W is a power of two.
// For cnt == 0 the result is dst and the carry output is 0 (caller ignores it).
module bitx_dshift #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic          left,
    input  logic [W-1:0]  dst,
    input  logic [W-1:0]  src,
    input  logic [IW-1:0] cnt,
    output logic [W-1:0]  res,
    output logic          cout
);
    logic [IW-1:0] rev;     // W - cnt, modulo W
    logic          nz;

    // Combine the shifted destination with the opposite end of the source.
    always_comb begin
        rev = IW'(W) - cnt;
        nz  = (cnt != '0);
        if (left) begin
            res  = (dst << cnt) | (nz ? (src >> rev) : '0);
            cout = nz ? dst[rev] : 1'b0;
        end else begin
            res  = (dst >> cnt) | (nz ? (src << rev) : '0);
            cout = nz ? dst[cnt - IW'(1)] : 1'b0;
        end
    end
endmodule

// File: rtl/bitx_unit.sv
// Single-cycle bit manipulation execution unit.
// Decodes the opcode, selects one sub-unit result, updates the flags, and
// registers everything one clock after in_valid. Assumes the inputs stay
// stable through the cycle in which in_valid is high.
module bitx_unit #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    in_op,
    input  logic          in_size,
    input  logic [W-1:0]  in_dst,
    input  logic [W-1:0]  in_src,
    input  logic [IW-1:0] in_cnt,
    input  logic          cf_in,
    input  logic          zf_in,
    output logic          out_valid,
    output logic [W-1:0]  res,
    output logic [W-1:0]  res_hi,
    output logic          cf,
    output logic          zf
);
    import bitx_pkg::*;

    bitx_op_e     op;
    logic [W-1:0] bit_res, ext_res, ext_hi, sh_res, ext_opnd;
    logic         bit_old, sh_cout;
    logic [IW-1:0] lo_idx, hi_idx;
    logic          lo_none, hi_none;
    logic [W-1:0] n_res, n_hi;
    logic         n_cf, n_zf;

    assign op       = bitx_op_e'(in_op);
    assign ext_opnd = (op == OP_HFILL || op == OP_WFILL) ? in_dst : in_src;

    bitx_bitop #(.W(W), .IW(IW)) u_bitop (
        .act(in_op[1:0]), .val(in_dst), .idx(in_cnt),
        .res(bit_res), .bit_old(bit_old));

    bitx_scan #(.W(W), .IW(IW), .REVERSE(1'b0)) u_scan_lo (
        .val(in_src), .idx(lo_idx), .none(lo_none));

    bitx_scan #(.W(W), .IW(IW), .REVERSE(1'b1)) u_scan_hi (
        .val(in_src), .idx(hi_idx), .none(hi_none));

    bitx_extend #(.W(W)) u_extend (
        .op(op), .size(in_size), .opnd(ext_opnd),
        .res(ext_res), .hi(ext_hi));

    bitx_dshift #(.W(W), .IW(IW)) u_dshift (
        .left(op == OP_FSHL), .dst(in_dst), .src(in_src), .cnt(in_cnt),
        .res(sh_res), .cout(sh_cout));

    // Select the result and the flag updates for the current opcode.
    always_comb begin
        n_res = in_dst;
        n_hi  = '0;
        n_cf  = cf_in;
        n_zf  = zf_in;
        case (op)
            OP_BTEST, OP_BSET, OP_BCLR, OP_BINV: begin
                n_res = bit_res;
                n_cf  = bit_old;
            end
            OP_SCANL: begin
                n_zf = lo_none;
                if (!lo_none) n_res = {{(W-IW){1'b0}}, lo_idx};
            end
            OP_SCANH: begin
                n_zf = hi_none;
                if (!hi_none) n_res = {{(W-IW){1'b0}}, hi_idx};
            end
            OP_SEXT, OP_ZEXT, OP_HFILL, OP_WFILL: begin
                n_res = ext_res;
                n_hi  = ext_hi;
            end
            OP_FSHL, OP_FSHR: begin
                if (in_cnt != '0) begin
                    n_res = sh_res;
                    n_cf  = sh_cout;
                    n_zf  = (sh_res == '0);
                end
            end
            default: ;
        endcase
    end

    // Register the outputs; synchronous active-low reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res       <= '0;
            res_hi    <= '0;
            cf        <= 1'b0;
            zf        <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res    <= n_res;
                res_hi <= n_hi;
                cf     <= n_cf;
                zf     <= n_zf;
            end
        end
    end

    AST_TEST_KEEPS_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(in_op) == OP_BTEST |-> res == $past(in_dst) && cf == $past(in_dst[in_cnt])); // R1

    AST_EMPTY_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && ($past(in_op) == OP_SCANL || $past(in_op) == OP_SCANH) && $past(in_src) == '0
        |-> zf && res == $past(in_dst)); // R4

    AST_WFILL_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(in_op) == OP_WFILL |-> ($countones(res_hi) == 0 || $countones(res_hi) == W)); // R7

    AST_ZERO_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && ($past(in_op) == OP_FSHL || $past(in_op) == OP_FSHR) && $past(in_cnt) == '0
        |-> res == $past(in_dst) && cf == $past(cf_in) && zf == $past(zf_in)); // R10

    AST_HI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(in_op) != OP_WFILL |-> res_hi == '0); // R11
endmodule

// File: tb/tb_bitx_unit.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops and compares.
module tb_bitx_unit;
    import bitx_pkg::*;

    typedef struct {
        logic [31:0] res;
        logic [31:0] hi;
        logic        cf;
        logic        zf;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic        in_size = 1'b0;
    logic [31:0] in_dst = '0, in_src = '0;
    logic [4:0]  in_cnt = '0;
    logic        cf_in = 1'b0, zf_in = 1'b0;
    logic        out_valid;
    logic [31:0] res, res_hi;
    logic        cf, zf;

    int checks = 0;
    int fails  = 0;
    exp_t sb[$];

    always #10 clk = ~clk;   // 50 MHz

    bitx_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_size(in_size), .in_dst(in_dst), .in_src(in_src), .in_cnt(in_cnt),
        .cf_in(cf_in), .zf_in(zf_in), .out_valid(out_valid), .res(res),
        .res_hi(res_hi), .cf(cf), .zf(zf));

    // Expected-value model written from the requirements.
    function automatic exp_t model(logic [3:0] op, logic sz, logic [31:0] d,
                                   logic [31:0] s, int n, logic ci, logic zi);
        exp_t e;
        bit found;
        e.res = d; e.hi = '0; e.cf = ci; e.zf = zi; e.tag = "";
        case (op)
            4'd0, 4'd1, 4'd2, 4'd3: begin
                e.cf = d[n];
                if (op == 4'd1) e.res[n] = 1'b1;
                if (op == 4'd2) e.res[n] = 1'b0;
                if (op == 4'd3) e.res[n] = ~d[n];
            end
            4'd4, 4'd5: begin
                if (s == 0) e.zf = 1'b1;
                else begin
                    e.zf = 1'b0;
                    found = 1'b0;
                    for (int i = 0; i < 32; i++) begin
                        int k;
                        k = (op == 4'd4) ? i : 31 - i;
                        if (!found && s[k]) begin e.res = k; found = 1'b1; end
                    end
                end
            end
            4'd6: e.res = sz ? {{16{s[15]}}, s[15:0]} : {{24{s[7]}}, s[7:0]};
            4'd7: e.res = sz ? {16'h0, s[15:0]} : {24'h0, s[7:0]};
            4'd8: e.res = {{16{d[15]}}, d[15:0]};
            4'd9: e.hi  = d[31] ? 32'hFFFF_FFFF : 32'h0;
            4'd10: if (n != 0) begin
                for (int i = 0; i < 32; i++)
                    e.res[i] = (i >= n) ? d[i-n] : s[32-n+i];
                e.cf = d[32-n];
                e.zf = (e.res == 0);
            end
            4'd11: if (n != 0) begin
                for (int i = 0; i < 32; i++)
                    e.res[i] = (i + n < 32) ? d[i+n] : s[i+n-32];
                e.cf = d[n-1];
                e.zf = (e.res == 0);
            end
            default: ;
        endcase
        return e;
    endfunction

    // Driver: apply one request on a falling edge and queue its expectation.
    task automatic drive(logic [3:0] op, logic sz, logic [31:0] d, logic [31:0] s,
                         int n, logic ci, logic zi, string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_size = sz; in_dst = d; in_src = s;
        in_cnt = 5'(n); cf_in = ci; zf_in = zi;
        e = model(op, sz, d, s, n % 32, ci, zi);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare each result on the falling edge after it appears.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R11: unexpected out_valid, res=%h expected no result", res);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (res !== e.res || res_hi !== e.hi || cf !== e.cf || zf !== e.zf) begin
                    fails++;
                    $display("FAIL %s: res=%h hi=%h cf=%b zf=%b expected res=%h hi=%h cf=%b zf=%b",
                             e.tag, res, res_hi, cf, zf, e.res, e.hi, e.cf, e.zf);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run incomplete, expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;   // R11 reset state
        if (out_valid !== 1'b0 || res !== '0 || res_hi !== '0 || cf !== 1'b0 || zf !== 1'b0) begin
            fails++;
            $display("FAIL R11: reset state v=%b res=%h hi=%h cf=%b zf=%b expected all zero",
                     out_valid, res, res_hi, cf, zf);
        end
        // R1 test only
        drive(OP_BTEST, 0, 32'h0F0F_0F0F, 0, 5, 1, 1, "R1");
        drive(OP_BTEST, 0, 32'h0F0F_0F0F, 0, 0, 0, 0, "R1");
        drive(OP_BTEST, 0, 32'h8000_0000, 0, 31, 0, 1, "R1");
        // R2 modify
        drive(OP_BSET, 0, 32'h0F0F_0F0F, 0, 5, 1, 0, "R2");
        drive(OP_BCLR, 0, 32'h0F0F_0F1F, 0, 4, 0, 1, "R2");
        drive(OP_BINV, 0, 32'h8000_0000, 0, 31, 0, 0, "R2");
        drive(OP_BINV, 0, 32'h0000_0000, 0, 17, 1, 0, "R2");
        // R3 and R4 scans
        drive(OP_SCANL, 0, 32'h1234_5678, 32'h00F0_0000, 0, 1, 1, "R3");
        drive(OP_SCANH, 0, 32'h1234_5678, 32'h00F0_0000, 0, 0, 1, "R3");
        drive(OP_SCANL, 0, 32'h0, 32'h8000_0000, 0, 0, 0, "R3");
        drive(OP_SCANH, 0, 32'h0, 32'h0000_0001, 0, 1, 0, "R3");
        drive(OP_SCANL, 0, 32'hDEAD_BEEF, 32'h0, 0, 1, 0, "R4");
        drive(OP_SCANH, 0, 32'hCAFE_F00D, 32'h0, 0, 0, 0, "R4");
        // R5 extensions
        drive(OP_SEXT, 0, 0, 32'h1234_5680, 0, 1, 0, "R5");
        drive(OP_SEXT, 1, 0, 32'hAAAA_87FE, 0, 0, 1, "R5");
        drive(OP_ZEXT, 1, 0, 32'hAAAA_87FE, 0, 0, 0, "R5");
        drive(OP_ZEXT, 0, 0, 32'hFFFF_FF7F, 0, 1, 1, "R5");
        drive(OP_SEXT, 0, 0, 32'h0000_007F, 0, 0, 0, "R5");
        // R6 halfword fill
        drive(OP_HFILL, 0, 32'h1234_8000, 0, 0, 1, 0, "R6");
        drive(OP_HFILL, 0, 32'h0F0F_0F0F, 0, 0, 0, 1, "R6");
        // R7 word fill
        drive(OP_WFILL, 0, 32'h8000_0001, 0, 0, 1, 1, "R7");
        drive(OP_WFILL, 0, 32'h0F0F_0F0F, 0, 0, 0, 0, "R7");
        // R8 left funnel
        drive(OP_FSHL, 0, 32'hF888_09CF, 32'h1FFF_FE00, 3, 0, 1, "R8");
        drive(OP_FSHL, 0, 32'h0000_0001, 32'hFFFF_FFFF, 31, 0, 0, "R8");
        drive(OP_FSHL, 0, 32'h8000_0000, 32'h0000_0000, 1, 0, 0, "R8");
        // R9 right funnel
        drive(OP_FSHR, 0, 32'hF888_09CF, 32'hCF0A_5C98, 4, 0, 0, "R9");
        drive(OP_FSHR, 0, 32'h8000_0000, 32'h0000_0001, 31, 1, 1, "R9");
        drive(OP_FSHR, 0, 32'h0000_0001, 32'h0000_0000, 1, 0, 0, "R9");
        // R10 zero count
        drive(OP_FSHL, 0, 32'h1357_9BDF, 32'hFFFF_FFFF, 0, 1, 0, "R10");
        drive(OP_FSHR, 0, 32'h2468_ACE0, 32'hFFFF_FFFF, 0, 0, 1, "R10");
        // R11 unused opcodes
        drive(4'd12, 0, 32'hA5A5_5A5A, 32'h1111_1111, 7, 1, 1, "R11");
        drive(4'd15, 1, 32'h0000_FFFF, 32'h2222_2222, 3, 0, 0, "R11");
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        checks++;   // R11 every request produced one result
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R11: %0d results missing, expected 0", sb.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule